// File: doc/BRIEF.md
# Segmented Capture Trigger Controller

This block decides which ADC samples are written into a sample buffer. It watches a trigger line and a sample-valid strobe, and it drives a per-sample write enable. Software programs a trigger-to-capture delay, a window length and a segment count, then arms the block. Each accepted trigger starts a delay of a set number of valid samples. After the delay the block opens a write window of a set length. It repeats this once per segment and then raises a done flag.

Triggers can arrive while a delay or a window is already running. Such triggers are discarded. Any partial count is cleared on every arm, and the counters return to zero when their own stage ends. As a result the block always reaches done and can always be armed again, however dense the triggers are. An optional watchdog forces a trigger when none arrives in time and marks the capture as untrustworthy.

Top module: `segcap_ctrl`

## Requirements
- R1: After reset, armed, capturing, done, data_invalid, cap_en and seg_idx are all 0. The configuration resets to offset 0, length 1, segments 1 and timeout 0.
- R2: A cycle with arm high restarts the block on the next clock edge: armed goes to 1, and done, data_invalid, seg_idx and all internal counts go to 0. This holds in every state.
- R3: Only a rising edge of trig_in seen while waiting for a trigger is accepted. A rising edge is trig_in high in a cycle after a cycle where it was low. A level held high counts as one trigger only. A level already high when the block is armed is not a trigger.
- R4: After an accepted trigger, the block skips exactly OFFSET sample_valid strobes and then enters capture. With OFFSET equal to 0, capture starts on the clock edge that accepts the trigger.
- R5: cap_en equals capturing AND sample_valid. Each segment asserts cap_en on exactly LENGTH strobes.
- R6: After LENGTH strobes the segment ends. If fewer than SEGMENTS segments are complete, the block returns to waiting and seg_idx advances by one. After the last segment, done goes to 1 and armed goes to 0. done then stays 1 until the next arm, and seg_idx returns to 0.
- R7: Triggers that arrive during an offset count or a capture window have no effect. The run still completes with the programmed number of samples and can be re-armed without reset.
- R8: With TIMEOUT not 0, a block that waits TIMEOUT cycles without a rising edge forces a trigger and sets data_invalid. data_invalid stays set until the next arm. A rising edge in that same last cycle counts as a real trigger. TIMEOUT 0 waits forever.
- R9: Registers are written with cfg_we at these cfg_addr values: 0 is OFFSET, 1 is LENGTH, 2 is SEGMENTS, 3 is TIMEOUT, each taken from the low bits of cfg_wdata. Writes are ignored while armed. A LENGTH or SEGMENTS write of 0 stores 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| arm | input | 1 | Start (or restart) a capture run |
| trig_in | input | 1 | Trigger line, edge-detected |
| sample_valid | input | 1 | One-cycle strobe per ADC sample |
| cap_en | output | 1 | Write enable for the current sample |
| armed | output | 1 | Run in progress |
| capturing | output | 1 | Capture window open |
| done | output | 1 | All segments captured |
| data_invalid | output | 1 | A trigger was forced by timeout |
| seg_idx | output | 8 | Index of the segment being captured |

## Verification
The assertions assume that trig_in, arm and sample_valid are already synchronous to clk. They also assume that the configuration stays as written once a run starts, and the block enforces that itself. The stimulus changes every input only on the falling clock edge. It mixes dense, sparse and pseudo-random sample strobes. It sends trigger bursts spaced closer than the window, holds the trigger high across a segment boundary, writes configuration while armed, and re-arms in the middle of a window.

// File: rtl/segcap_pkg.sv
package segcap_pkg;

   typedef enum logic [1:0] {
      SC_IDLE = 2'd0,
      SC_WAIT = 2'd1,
      SC_OFFS = 2'd2,
      SC_CAPT = 2'd3
   } sc_state_e;

   localparam logic [1:0] SC_REG_OFFSET = 2'd0;
   localparam logic [1:0] SC_REG_LENGTH = 2'd1;
   localparam logic [1:0] SC_REG_SEGS   = 2'd2;
   localparam logic [1:0] SC_REG_TMO    = 2'd3;

endpackage

// File: rtl/segcap_cfg.sv
module segcap_cfg
   import segcap_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int OFS_W       = 16,
   parameter int SMP_W       = 16,
   parameter int SEG_W       = 8,
   parameter int TMO_W       = 16,
   parameter bit HAS_TIMEOUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              lock,
   output logic [OFS_W-1:0]  ofs_o,
   output logic [SMP_W-1:0]  smp_o,
   output logic [SEG_W-1:0]  seg_o,
   output logic [TMO_W-1:0]  tmo_o
);

   localparam logic [SMP_W-1:0] SMP_ONE = SMP_W'(1);
   localparam logic [SEG_W-1:0] SEG_ONE = SEG_W'(1);

   logic              wr_ok;
   logic [SMP_W-1:0]  smp_in;
   logic [SEG_W-1:0]  seg_in;

   // writes only land while no run is in progress
   assign wr_ok  = wr_en && !lock;
   assign smp_in = (wr_data[SMP_W-1:0] == '0) ? SMP_ONE : wr_data[SMP_W-1:0];
   assign seg_in = (wr_data[SEG_W-1:0] == '0) ? SEG_ONE : wr_data[SEG_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_o <= '0;
         smp_o <= SMP_ONE;
         seg_o <= SEG_ONE;
      end else if (wr_ok) begin
         if (wr_addr == SC_REG_OFFSET) ofs_o <= wr_data[OFS_W-1:0];
         if (wr_addr == SC_REG_LENGTH) smp_o <= smp_in;
         if (wr_addr == SC_REG_SEGS)   seg_o <= seg_in;
      end
   end

   generate
      if (HAS_TIMEOUT) begin : g_tmo_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tmo_o <= '0;
            else if (wr_ok && wr_addr == SC_REG_TMO)
               tmo_o <= wr_data[TMO_W-1:0];
         end
      end else begin : g_tmo_none
         assign tmo_o = '0;
      end
   endgenerate

   // R9: a locked register bank never changes
   p_locked_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(ofs_o) && $stable(smp_o) && $stable(seg_o) && $stable(tmo_o));

   // R9: zero never reaches the length or segment registers
   p_no_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_o != '0) && (seg_o != '0));

endmodule

// File: rtl/segcap_cnt.sv
module segcap_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] limit,
   output logic [W-1:0] cnt,
   output logic         last
);

   logic [W-1:0] cnt_q;

   assign cnt  = cnt_q;
   assign last = inc && (cnt_q == limit - W'(1));

   // wraps to zero on its own final step, so no stale count survives a stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (last)
         cnt_q <= '0;
      else if (inc)
         cnt_q <= cnt_q + W'(1);
   end

   // R5: a running count never passes its limit
   p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> (cnt_q < limit));

endmodule

// File: rtl/segcap_trig.sv
module segcap_trig #(
   parameter int TMO_W       = 16,
   parameter bit HAS_TIMEOUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_in,
   input  logic             waiting,
   input  logic             restart,
   input  logic [TMO_W-1:0] tmo_lim,
   output logic             take,
   output logic             forced
);

   logic trig_q;
   logic rise;
   logic hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_q <= 1'b0;
      else        trig_q <= trig_in;
   end

   assign rise = trig_in && !trig_q;

   generate
      if (HAS_TIMEOUT) begin : g_watchdog
         logic [TMO_W-1:0] wait_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               wait_cnt <= '0;
            else if (!waiting || restart)
               wait_cnt <= '0;
            else
               wait_cnt <= wait_cnt + TMO_W'(1);
         end
         assign hit = waiting && (tmo_lim != '0) && (wait_cnt == tmo_lim - TMO_W'(1));
      end else begin : g_no_watchdog
         assign hit = 1'b0;
      end
   endgenerate

   assign take   = waiting && (rise || hit);
   assign forced = waiting && hit && !rise;

   // R3: a level that was already high is never taken as a new trigger
   p_level_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(trig_in) && trig_in && !forced) |-> !take);

endmodule

// File: rtl/segcap_ctrl.sv
module segcap_ctrl
   import segcap_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int OFS_W       = 16,
   parameter int SMP_W       = 16,
   parameter int SEG_W       = 8,
   parameter int TMO_W       = 16,
   parameter bit HAS_TIMEOUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              arm,
   input  logic              trig_in,
   input  logic              sample_valid,
   output logic              cap_en,
   output logic              armed,
   output logic              capturing,
   output logic              done,
   output logic              data_invalid,
   output logic [SEG_W-1:0]  seg_idx
);

   generate
      if (OFS_W > DATA_W || SMP_W > DATA_W || SEG_W > DATA_W || TMO_W > DATA_W) begin : g_bad_width
         $error("segcap_ctrl: a field is wider than the configuration bus");
      end
      if (OFS_W < 1 || SMP_W < 1 || SEG_W < 1 || TMO_W < 2) begin : g_bad_min
         $error("segcap_ctrl: field width too small");
      end
   endgenerate

   sc_state_e        st_q, st_nx;
   logic [OFS_W-1:0] ofs_lim, ofs_cnt;
   logic [SMP_W-1:0] smp_lim, smp_cnt;
   logic [SEG_W-1:0] seg_lim, seg_cnt;
   logic [TMO_W-1:0] tmo_lim;
   logic             busy, waiting, take, forced;
   logic             ofs_inc, smp_inc, ofs_last, smp_last, seg_last;
   logic             done_q, inv_q;

   assign busy    = (st_q != SC_IDLE);
   assign waiting = (st_q == SC_WAIT);

   segcap_cfg #(
      .DATA_W(DATA_W), .OFS_W(OFS_W), .SMP_W(SMP_W),
      .SEG_W(SEG_W), .TMO_W(TMO_W), .HAS_TIMEOUT(HAS_TIMEOUT)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
      .wr_data(cfg_wdata), .lock(busy),
      .ofs_o(ofs_lim), .smp_o(smp_lim), .seg_o(seg_lim), .tmo_o(tmo_lim)
   );

   segcap_trig #(.TMO_W(TMO_W), .HAS_TIMEOUT(HAS_TIMEOUT)) u_trig (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .waiting(waiting),
      .restart(arm), .tmo_lim(tmo_lim), .take(take), .forced(forced)
   );

   // one counter per stage; triggers outside the wait state never touch them
   assign ofs_inc = (st_q == SC_OFFS) && sample_valid;
   assign smp_inc = (st_q == SC_CAPT) && sample_valid;

   segcap_cnt #(.W(OFS_W)) u_ofs_cnt (
      .clk(clk), .rst_n(rst_n), .clr(arm), .inc(ofs_inc),
      .limit(ofs_lim), .cnt(ofs_cnt), .last(ofs_last)
   );

   segcap_cnt #(.W(SMP_W)) u_smp_cnt (
      .clk(clk), .rst_n(rst_n), .clr(arm), .inc(smp_inc),
      .limit(smp_lim), .cnt(smp_cnt), .last(smp_last)
   );

   segcap_cnt #(.W(SEG_W)) u_seg_cnt (
      .clk(clk), .rst_n(rst_n), .clr(arm), .inc(smp_last),
      .limit(seg_lim), .cnt(seg_cnt), .last(seg_last)
   );

   always_comb begin
      st_nx = st_q;
      unique case (st_q)
         SC_IDLE: st_nx = SC_IDLE;
         SC_WAIT: if (take)     st_nx = (ofs_lim == '0) ? SC_CAPT : SC_OFFS;
         SC_OFFS: if (ofs_last) st_nx = SC_CAPT;
         SC_CAPT: if (smp_last) st_nx = seg_last ? SC_IDLE : SC_WAIT;
         default: st_nx = SC_IDLE;
      endcase
      if (arm) st_nx = SC_WAIT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SC_IDLE;
         done_q <= 1'b0;
         inv_q  <= 1'b0;
      end else begin
         st_q <= st_nx;
         if (arm) begin
            done_q <= 1'b0;
            inv_q  <= 1'b0;
         end else begin
            if (smp_last && seg_last) done_q <= 1'b1;
            if (forced)               inv_q  <= 1'b1;
         end
      end
   end

   assign cap_en       = (st_q == SC_CAPT) && sample_valid;
   assign armed        = busy;
   assign capturing    = (st_q == SC_CAPT);
   assign done         = done_q;
   assign data_invalid = inv_q;
   assign seg_idx      = seg_cnt;

   // R2: arm restarts from any state
   p_arm_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (armed && !done && !data_invalid && seg_idx == '0));

   // R4: zero offset opens the window straight from the accepting edge
   p_zero_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && take && ofs_lim == '0 && !arm) |=> capturing);

   // R7: outside its own stage each count sits at zero, so nothing stray lingers
   p_no_stray_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != SC_OFFS) |-> (ofs_cnt == '0));
   p_no_stray_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !capturing |-> (smp_cnt == '0));

   // R6: done only follows a final captured sample and excludes activity
   p_done_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(capturing && sample_valid));
   p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!armed && !capturing));

   // R8: the invalid flag only appears out of the wait state
   p_invalid_from_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_invalid) |-> $past(waiting));

endmodule

// File: tb/tb_segcap_ctrl.sv
`timescale 1ns/1ps
module tb_segcap_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [15:0] cfg_wdata = 16'd0;
   logic        arm = 1'b0;
   logic        trig_in = 1'b0;
   logic        sample_valid = 1'b0;
   logic        cap_en, armed, capturing, done, data_invalid;
   logic [7:0]  seg_idx;

   always #4 clk = ~clk;

   segcap_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .arm(arm), .trig_in(trig_in),
      .sample_valid(sample_valid), .cap_en(cap_en), .armed(armed),
      .capturing(capturing), .done(done), .data_invalid(data_invalid),
      .seg_idx(seg_idx)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cap_total = 0;
   bit finished = 0;

   function automatic void chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endfunction

   // ---------------- behavioural reference model ----------------
   int m_st = 0;           // 0 idle, 1 waiting, 2 offset, 3 capture
   int m_ofs = 0, m_len = 1, m_segs = 1, m_tmo = 0;
   int c_ofs = 0, c_len = 0, m_seg = 0, m_wait = 0;
   bit m_done = 0, m_inv = 0, m_tq = 0;

   always @(posedge clk) begin
      bit rise;
      int old_st;
      if (!rst_n) begin
         m_st = 0; m_ofs = 0; m_len = 1; m_segs = 1; m_tmo = 0;
         c_ofs = 0; c_len = 0; m_seg = 0; m_wait = 0;
         m_done = 0; m_inv = 0; m_tq = 0;
      end else begin
         rise = trig_in && !m_tq;
         m_tq = trig_in;
         old_st = m_st;
         if (arm) begin
            m_st = 1; m_done = 0; m_inv = 0;
            c_ofs = 0; c_len = 0; m_seg = 0; m_wait = 0;
         end else begin
            case (m_st)
               1: begin
                  if (rise || (m_tmo != 0 && m_wait == m_tmo - 1)) begin
                     if (!rise) m_inv = 1;
                     m_st = (m_ofs == 0) ? 3 : 2;
                     m_wait = 0;
                  end else m_wait++;
               end
               2: if (sample_valid) begin
                  c_ofs++;
                  if (c_ofs == m_ofs) begin c_ofs = 0; m_st = 3; end
               end
               3: if (sample_valid) begin
                  c_len++;
                  if (c_len == m_len) begin
                     c_len = 0;
                     m_seg++;
                     if (m_seg == m_segs) begin m_seg = 0; m_st = 0; m_done = 1; end
                     else m_st = 1;
                  end
               end
               default: ;
            endcase
         end
         if (cfg_we && old_st == 0) begin
            case (cfg_addr)
               2'd0: m_ofs = cfg_wdata;
               2'd1: m_len = (cfg_wdata == 0) ? 1 : cfg_wdata;
               2'd2: m_segs = (cfg_wdata[7:0] == 0) ? 1 : cfg_wdata[7:0];
               default: m_tmo = cfg_wdata;
            endcase
         end
      end
   end

   // compare against the model on every clock, between edges
   always @(posedge clk) begin
      #3;
      chk("R2", "armed", armed, (m_st != 0));
      chk("R4", "capturing", capturing, (m_st == 3));
      chk("R6", "done", done, m_done);
      chk("R8", "data_invalid", data_invalid, m_inv);
      chk("R6", "seg_idx", seg_idx, m_seg);
      chk("R5", "cap_en", cap_en, (m_st == 3) && sample_valid);
      if (cap_en) cap_total++;
   end

   // ---------------- sample strobe generator ----------------
   int sv_mode = 0;
   int cyc = 0;
   logic [7:0] lfsr = 8'hA5;
   always @(negedge clk) begin
      cyc++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (!rst_n) sample_valid = 1'b0;
      else case (sv_mode)
         0: sample_valid = 1'b1;
         1: sample_valid = (cyc % 3 == 0);
         default: sample_valid = lfsr[0];
      endcase
   end

   // ---------------- stimulus tasks ----------------
   task automatic cfg_write(input logic [1:0] a, input int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 16'(d);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_arm();
      @(negedge clk); arm = 1'b1;
      @(negedge clk); arm = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // drives a periodic trigger (per=0: none) until done or maxc cycles
   task automatic run(input int maxc, input int per, input int wid, output int got);
      int base = cap_total;
      for (int k = 0; k < maxc; k++) begin
         @(negedge clk);
         trig_in = (per > 0) && (k >= 1) && ((k % per) < wid);
         if (done) break;
      end
      trig_in = 1'b0;
      got = cap_total - base;
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int got;
      idle(3);
      @(negedge clk); rst_n = 1'b1;
      idle(2);
      // R1: reset state
      chk("R1", "armed after reset", armed, 0);
      chk("R1", "done after reset", done, 0);
      chk("R1", "cap_en after reset", cap_en, 0);
      chk("R1", "seg_idx after reset", seg_idx, 0);

      // R4 R5 R6: offset 3, length 5, two segments, sparse strobes
      sv_mode = 1;
      cfg_write(2'd0, 3); cfg_write(2'd1, 5); cfg_write(2'd2, 2);
      do_arm();
      run(2000, 60, 1, got);
      chk("R6", "samples over two segments", got, 10);
      chk("R6", "done after last segment", done, 1);
      chk("R6", "armed after last segment", armed, 0);

      // R4: zero offset, dense strobes
      sv_mode = 0;
      cfg_write(2'd0, 0); cfg_write(2'd1, 4); cfg_write(2'd2, 1);
      do_arm();
      run(200, 50, 1, got);
      chk("R4", "samples with zero offset", got, 4);

      // R7: triggers every 3 cycles during offset and capture, random strobes
      sv_mode = 2;
      cfg_write(2'd0, 6); cfg_write(2'd1, 8);
      do_arm();
      run(2000, 3, 1, got);
      chk("R7", "samples with dense triggers", got, 8);
      chk("R7", "done with dense triggers", done, 1);
      do_arm();
      run(2000, 3, 1, got);
      chk("R7", "re-armed run samples", got, 8);
      chk("R7", "re-armed run done", done, 1);

      // R3: held trigger level counts once
      sv_mode = 0;
      cfg_write(2'd0, 0); cfg_write(2'd1, 3); cfg_write(2'd2, 2);
      @(negedge clk); trig_in = 1'b1;
      do_arm();
      idle(30);
      chk("R3", "level high at arm not a trigger", capturing, 0);
      chk("R3", "still armed", armed, 1);
      got = cap_total;
      @(negedge clk); trig_in = 1'b0;
      @(negedge clk); trig_in = 1'b1;
      idle(30);
      chk("R3", "held level gave one segment", cap_total - got, 3);
      chk("R3", "segment index after one segment", seg_idx, 1);
      chk("R3", "not done while level held", done, 0);
      @(negedge clk); trig_in = 1'b0;
      run(200, 20, 1, got);
      chk("R3", "second segment after new edge", done, 1);

      // R8: forced triggers set data_invalid
      cfg_write(2'd0, 2); cfg_write(2'd1, 4); cfg_write(2'd3, 25);
      do_arm();
      run(500, 0, 0, got);
      chk("R8", "samples from forced triggers", got, 8);
      chk("R8", "invalid after forced trigger", data_invalid, 1);
      do_arm();
      chk("R2", "arm clears invalid", data_invalid, 0);
      chk("R2", "arm clears done", done, 0);
      run(500, 5, 1, got);
      chk("R8", "real trigger keeps data valid", data_invalid, 0);
      cfg_write(2'd3, 0);
      do_arm();
      idle(100);
      chk("R8", "timeout 0 keeps waiting", armed, 1);
      chk("R8", "timeout 0 no invalid", data_invalid, 0);
      run(500, 5, 1, got);

      // R9: writes while armed are ignored; zero length stores 1
      cfg_write(2'd0, 0); cfg_write(2'd1, 5); cfg_write(2'd2, 1);
      do_arm();
      cfg_write(2'd1, 9);
      run(500, 10, 1, got);
      chk("R9", "length written while armed ignored", got, 5);
      cfg_write(2'd1, 0);
      do_arm();
      run(500, 10, 1, got);
      chk("R9", "zero length stored as one", got, 1);

      // R10 -> R2: arm in the middle of a window restarts
      cfg_write(2'd1, 50);
      do_arm();
      @(negedge clk); trig_in = 1'b1;
      @(negedge clk); trig_in = 1'b0;
      idle(10);
      chk("R5", "window open mid-capture", capturing, 1);
      do_arm();
      chk("R2", "arm mid-capture closes window", capturing, 0);
      chk("R2", "arm mid-capture armed", armed, 1);
      run(500, 80, 1, got);
      chk("R2", "restarted run full length", got, 50);

      idle(5);
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule